// File: doc/BRIEF.md
# Interruptible Multi-Register Transfer Sequencer

The block walks a 16-entry register list for a load-multiple or store-multiple operation. It presents one register index per cycle to a register-file or memory stage, lowest index first, and skips every index whose list bit is clear. A start command latches the list and the transfer direction. A done pulse marks the cycle in which the final listed register is issued.

An interrupt request can arrive while the list is being walked. The register issued in that cycle still completes. The sequencer then parks in a suspended state and holds only a 4-bit continuation index, which is the next register still owed. That index appears in bits 15:12 of a 32-bit status word. Every other bit of the word reads zero, including the fields at 26:25 and 11:10 that would otherwise carry conditional-block state. When the handler has finished, the caller issues a resume command and presents the list again. The walk restarts at the saved index and runs to the end of the list. An interrupt that lands on the final transfer is not a suspension, because the operation simply completes.

States: `ST_IDLE` (no transfer), `ST_RUN` (issuing one register per cycle), `ST_HOLD` (suspended with continuation index). Transitions:
- idle→run on start.
- run→run while registers remain and no interrupt is pending.
- run→idle on the final (or empty) issue.
- run→hold on an interrupt with registers still owed.
- hold→run on resume.

Top module: `mrt_seq`

## Requirements
- R1: One cycle after `start_i` is accepted in idle, the block begins issuing. It issues one register per cycle in ascending index order, covering only indices whose bit in `list_i` is 1. `issue_load_o` repeats the `load_i` value latched at start.
- R2: `done_o` is 1 in the same cycle as the issue of the last listed register. For an empty list, `done_o` is 1 in the cycle after start, and no issue is made.
- R3: If `irq_i` is 1 in a run cycle while more listed registers remain after the one issued, that issue still completes. From the next cycle, `suspended_o` is 1 and no issues are made.
- R4: While suspended, `status_o[15:12]` holds the index of the next register still to transfer. It stays unchanged until resume.
- R5: While suspended, `status_o[26:25]` and `status_o[11:10]` are zero, as is every bit outside 15:12.
- R6: While not suspended, `status_o` is all zero.
- R7: `resume_i` in the suspended state restarts issuing on the next cycle. Issuing starts at the saved index and covers the bits of the presented `list_i` at or above that index, ending with `done_o`.
- R8: An `irq_i` in the cycle of the final transfer does not suspend. `done_o` is 1 and the block returns to idle.
- R9: `start_i` is ignored unless idle, `resume_i` is ignored unless suspended, and `irq_i` is ignored unless running.
- R10: After reset the block is idle, and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new transfer (idle only) |
| list_i | input | 16 | Register list mask, sampled on start and on resume |
| load_i | input | 1 | Direction: 1 = load, 0 = store, latched on start |
| irq_i | input | 1 | Interrupt request, acts only during run |
| resume_i | input | 1 | Continue a suspended transfer |
| issue_valid_o | output | 1 | A register index is issued this cycle |
| issue_idx_o | output | 4 | Index of the issued register |
| issue_load_o | output | 1 | Direction of the issued transfer |
| done_o | output | 1 | Final register issued (or empty list finished) |
| busy_o | output | 1 | Block is running or suspended |
| suspended_o | output | 1 | Transfer is parked awaiting resume |
| status_o | output | 32 | Status word, continuation index at 15:12 |

## Verification
The bench builds the block with its default 16-entry list, so the continuation field is exactly four bits wide and every index from 1 to 15 can be saved. That makes the top index reachable both as a saved continuation and as a final transfer. Random lists, interrupt timing and resumes with a changed list are mixed with directed cases: an empty list, a single-register list, a suspension that saves index 15, and commands sent in the wrong state.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;

    localparam int STAT_W   = 32;
    localparam int CONT_LSB = 12;
endpackage

// File: rtl/mrt_lowest.sv
module mrt_lowest #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // priority pick of the least significant set bit
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mrt_floor_mask.sv
module mrt_floor_mask #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] base_i,
    output logic [W-1:0]  mask_o
);
    // bit g set when g is at or above the base index
    for (genvar g = 0; g < W; g++) begin : g_cmp
        assign mask_o[g] = (base_i <= IW'(g));
    end
endmodule

// File: rtl/mrt_status_pack.sv
module mrt_status_pack
    import mrt_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic              hold_i,
    input  logic [IW-1:0]     idx_i,
    output logic [STAT_W-1:0] word_o
);
    // only the continuation field can be non-zero, and only while held
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b >= CONT_LSB && b < CONT_LSB + IW) begin : g_fld
            assign word_o[b] = hold_i & idx_i[b-CONT_LSB];
        end else begin : g_zero
            assign word_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
    import mrt_pkg::*;
#(
    parameter int LIST_W = 16,
    localparam int IW    = $clog2(LIST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LIST_W-1:0] list_i,
    input  logic              load_i,
    input  logic              irq_i,
    input  logic              resume_i,
    output logic              issue_valid_o,
    output logic [IW-1:0]     issue_idx_o,
    output logic              issue_load_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              suspended_o,
    output logic [STAT_W-1:0] status_o
);
    seq_state_e        state_q, state_n;
    logic [LIST_W-1:0] rem_q, rem_n;
    logic [IW-1:0]     cont_q, cont_n;
    logic              load_q, load_n;

    logic              first_found;
    logic [IW-1:0]     first_idx;
    logic [LIST_W-1:0] first_oh;
    logic [LIST_W-1:0] rest;
    logic              more;
    logic [IW-1:0]     next_idx;
    logic [LIST_W-1:0] floor_mask;

    // current register to issue
    mrt_lowest #(.W(LIST_W), .IW(IW)) u_pick_cur (
        .vec_i   (rem_q),
        .found_o (first_found),
        .idx_o   (first_idx)
    );

    assign first_oh = LIST_W'(1) << first_idx;
    assign rest     = rem_q & ~first_oh;

    // lookahead: register owed after the current one
    mrt_lowest #(.W(LIST_W), .IW(IW)) u_pick_next (
        .vec_i   (rest),
        .found_o (more),
        .idx_o   (next_idx)
    );

    // resume window from the saved index upward
    mrt_floor_mask #(.W(LIST_W), .IW(IW)) u_floor (
        .base_i (cont_q),
        .mask_o (floor_mask)
    );

    mrt_status_pack #(.IW(IW)) u_status (
        .hold_i (state_q == ST_HOLD),
        .idx_i  (cont_q),
        .word_o (status_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            cont_q  <= '0;
            load_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            rem_q   <= rem_n;
            cont_q  <= cont_n;
            load_q  <= load_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        rem_n   = rem_q;
        cont_n  = cont_q;
        load_n  = load_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_n = ST_RUN;
                    rem_n   = list_i;
                    load_n  = load_i;
                end
            end
            ST_RUN: begin
                if (!more) begin
                    // final or empty issue: interrupt has nothing to split
                    state_n = ST_IDLE;
                    rem_n   = '0;
                end else if (irq_i) begin
                    state_n = ST_HOLD;
                    cont_n  = next_idx;
                    rem_n   = '0;
                end else begin
                    rem_n   = rest;
                end
            end
            ST_HOLD: begin
                if (resume_i) begin
                    state_n = ST_RUN;
                    rem_n   = list_i & floor_mask;
                    cont_n  = '0;
                end
            end
            default: begin
                state_n = ST_IDLE;
                rem_n   = '0;
                cont_n  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        issue_valid_o = 1'b0;
        issue_idx_o   = '0;
        issue_load_o  = 1'b0;
        done_o        = 1'b0;
        busy_o        = 1'b0;
        suspended_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RUN: begin
                busy_o        = 1'b1;
                issue_valid_o = first_found;
                issue_idx_o   = first_idx;
                issue_load_o  = first_found & load_q;
                done_o        = !more;
            end
            ST_HOLD: begin
                busy_o      = 1'b1;
                suspended_o = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/mrt_seq_chk.sv
module mrt_seq_chk
    import mrt_pkg::*;
#(
    parameter int LIST_W = 16,
    localparam int IW    = $clog2(LIST_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_i,
    input logic              resume_i,
    input logic              issue_valid_o,
    input logic [IW-1:0]     issue_idx_o,
    input logic              done_o,
    input logic              suspended_o,
    input logic [STAT_W-1:0] status_o
);
    p_ascending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !done_o) |=> (!issue_valid_o || (issue_idx_o > $past(issue_idx_o))));

    p_hold_needs_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended_o) |-> $past(irq_i));

    p_no_issue_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        suspended_o |-> !issue_valid_o);

    p_cont_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && $past(suspended_o)) |-> $stable(status_o));

    p_fields_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        suspended_o |-> (status_o[26:25] == 2'b00 && status_o[11:10] == 2'b00));

    p_free_status_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !suspended_o |-> (status_o == '0));

    p_resume_leaves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && resume_i) |=> !suspended_o);

    p_final_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !suspended_o);
endmodule

bind mrt_seq mrt_seq_chk #(.LIST_W(LIST_W)) u_mrt_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_i         (irq_i),
    .resume_i      (resume_i),
    .issue_valid_o (issue_valid_o),
    .issue_idx_o   (issue_idx_o),
    .done_o        (done_o),
    .suspended_o   (suspended_o),
    .status_o      (status_o)
);

// File: tb/mrt_seq_tb_top.sv
module mrt_seq_tb_top;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  list_i = '0;
    logic          load_i = 1'b0;
    logic          irq_i = 1'b0;
    logic          resume_i = 1'b0;
    logic          issue_valid_o;
    logic [3:0]    issue_idx_o;
    logic          issue_load_o;
    logic          done_o;
    logic          busy_o;
    logic          suspended_o;
    logic [31:0]   status_o;

    always #4 clk = ~clk;

    mrt_seq #(.LIST_W(W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .list_i        (list_i),
        .load_i        (load_i),
        .irq_i         (irq_i),
        .resume_i      (resume_i),
        .issue_valid_o (issue_valid_o),
        .issue_idx_o   (issue_idx_o),
        .issue_load_o  (issue_load_o),
        .done_o        (done_o),
        .busy_o        (busy_o),
        .suspended_o   (suspended_o),
        .status_o      (status_o)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state: 0 idle, 1 run, 2 suspended
    int          m_st   = 0;
    logic [15:0] m_rem  = '0;
    logic [3:0]  m_cont = '0;
    logic        m_load = 1'b0;

    function automatic int low_idx(logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(logic st, logic [15:0] lst, logic ld, logic irq, logic res);
        logic        e_valid, e_done, e_load;
        logic [3:0]  e_idx;
        logic [31:0] e_stat;
        int          li;
        logic [15:0] nr;
        @(negedge clk);
        start_i = st; list_i = lst; load_i = ld; irq_i = irq; resume_i = res;
        #1;
        e_valid = 0; e_done = 0; e_load = 0; e_idx = 0;
        li = low_idx(m_rem);
        if (m_st == 1) begin
            if (li >= 0) begin
                e_valid = 1; e_idx = 4'(li); e_load = m_load;
                e_done = ($countones(m_rem) == 1);
            end else begin
                e_done = 1;
            end
        end
        e_stat = (m_st == 2) ? {16'h0, m_cont, 12'h0} : 32'h0;
        chk(issue_valid_o == e_valid, "R1 valid", 32'(issue_valid_o), 32'(e_valid));
        if (e_valid) begin
            chk(issue_idx_o == e_idx, "R1 idx", 32'(issue_idx_o), 32'(e_idx));
            chk(issue_load_o == e_load, "R1 load", 32'(issue_load_o), 32'(e_load));
        end
        chk(done_o == e_done, "R2 done", 32'(done_o), 32'(e_done));
        chk(suspended_o == (m_st == 2), "R3 suspended", 32'(suspended_o), 32'(m_st == 2));
        chk(busy_o == (m_st != 0), "R9 busy", 32'(busy_o), 32'(m_st != 0));
        if (m_st == 2) begin
            chk(status_o == e_stat, "R4 status", status_o, e_stat);
            chk(status_o[26:25] == 0 && status_o[11:10] == 0, "R5 zero fields",
                status_o, e_stat);
        end else begin
            chk(status_o == 32'h0, "R6 status", status_o, 32'h0);
        end
        // model next state
        case (m_st)
            0: if (st) begin m_st = 1; m_rem = lst; m_load = ld; end
            1: begin
                if (li < 0 || $countones(m_rem) == 1) begin
                    m_st = 0; m_rem = '0;
                end else begin
                    nr = m_rem & ~(16'h1 << li);
                    if (irq) begin
                        m_st = 2; m_cont = 4'(low_idx(nr)); m_rem = '0;
                    end else begin
                        m_rem = nr;
                    end
                end
            end
            default: if (res) begin m_st = 1; m_rem = lst & (16'hFFFF << m_cont); end
        endcase
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        chk({issue_valid_o, issue_idx_o, issue_load_o, done_o, busy_o, suspended_o} == 0
            && status_o == 0, "R10 reset outputs", status_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // suspend after first issue, saved index 5
        step(1, 16'h8421, 1, 0, 0);
        step(0, 16'h0, 0, 1, 0);
        step(0, 16'h0, 0, 0, 0);
        chk(status_o == 32'h0000_5000, "R4 saved index 5", status_o, 32'h5000);
        // wrong-state commands while held
        step(1, 16'h0003, 0, 1, 0);
        step(0, 16'h0, 0, 0, 0);
        chk(suspended_o && status_o == 32'h5000, "R9 start/irq in hold", status_o, 32'h5000);
        // resume
        step(0, 16'h8421, 0, 0, 1);
        step(0, 16'h0, 0, 0, 0);
        chk(issue_valid_o && issue_idx_o == 5, "R7 resume idx5", 32'(issue_idx_o), 32'd5);
        step(0, 16'h0, 0, 0, 0);
        chk(issue_idx_o == 10, "R7 resume idx10", 32'(issue_idx_o), 32'd10);
        step(0, 16'h0, 0, 0, 0);
        chk(issue_idx_o == 15 && done_o, "R7 resume idx15 done", 32'(issue_idx_o), 32'd15);

        // final transfer interrupted
        step(1, 16'h0100, 0, 0, 0);
        step(0, 16'h0, 0, 1, 0);
        chk(done_o && issue_idx_o == 8, "R8 done on final", 32'(done_o), 32'd1);
        step(0, 16'h0, 0, 0, 0);
        chk(!suspended_o && !busy_o, "R8 no suspend", 32'(suspended_o), 32'd0);

        // empty list
        step(1, 16'h0, 1, 0, 0);
        step(0, 16'h0, 0, 0, 0);
        chk(done_o && !issue_valid_o, "R2 empty list", 32'(done_o), 32'd1);

        // saved index 15, resume with a wider list
        step(1, 16'hC000, 0, 0, 0);
        step(0, 16'h0, 0, 1, 0);
        step(0, 16'h0, 0, 0, 0);
        chk(status_o == 32'h0000_F000, "R4 saved index 15", status_o, 32'hF000);
        step(0, 16'hFFFF, 0, 0, 1);
        step(0, 16'h0, 0, 0, 0);
        chk(issue_idx_o == 15 && done_o, "R7 resume at 15", 32'(issue_idx_o), 32'd15);

        // resume and irq while idle
        step(0, 16'hFFFF, 0, 1, 1);
        step(0, 16'h0, 0, 0, 0);
        chk(!busy_o, "R9 resume in idle", 32'(busy_o), 32'd0);

        // random transfers
        for (int n = 0; n < 400; n++) begin
            logic [15:0] lst;
            lst = 16'($urandom);
            if ($urandom_range(0, 7) == 0) lst = lst & 16'($urandom);
            step(1, lst, 1'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            for (int c = 0; c < 80 && m_st != 0; c++) begin
                logic [15:0] rl;
                rl = ($urandom_range(0, 3) == 0) ? 16'($urandom) : lst;
                step(1'($urandom_range(0, 1)), rl, 1'($urandom),
                     ($urandom_range(0, 3) == 0),
                     (m_st == 2) && ($urandom_range(0, 2) == 0));
            end
            if ($urandom_range(0, 3) == 0)
                step(0, 16'($urandom), 0, 1'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule